// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block keeps the running source and destination addresses of one DMA channel. After each completed transfer it moves both addresses by a step that depends on a shared transfer-size code. Each address has its own direction: held, counting up or counting down. A start address can be loaded into either register at any time. A combinational check flags mode and size combinations that are not allowed, and no address moves while the flag is up.

In single-address mode only one side is a memory address. The other side is an external device served through the acknowledge strobe. The mode of that device-side address plays no part: the address is not moved and its mode is not checked. The block also drives the acknowledge strobe. Its polarity comes from a writable level bit, which exists only when the channel is built with an external strobe pin.

Top module: `dma_addr_seq`

## Requirements
- R1: Mode code 2'b00 holds the address, 2'b01 adds the step and 2'b10 subtracts it. The size code sets the step: 2'b00 byte = 1, 2'b01 word = 2, 2'b10 longword = 4, 2'b11 16-byte burst = 16.
- R2: Both addresses move on the rising edge at which xfer_done_i is sampled high. Arithmetic wraps modulo 2^AW.
- R3: Mode code 2'b11 on a source or destination address that is in use drives config_error_o high in the same cycle.
- R4: With size 2'b11, a mode of 2'b00 or 2'b10 on an address in use drives config_error_o high.
- R5: While config_error_o is high, xfer_done_i moves neither address.
- R6: A load strobe for an address wins over an update in the same cycle. The address takes the load value on the next edge, and the other address still updates.
- R7: With single_addr_i high, dev_to_mem_i = 1 ignores the source side and dev_to_mem_i = 0 ignores the destination side. The ignored address holds its value, and its mode never raises config_error_o.
- R8: When ack_lvl_o is 0 the strobe dack_o is active low; when it is 1 the strobe is active high. dack_o is active in exactly the cycles where ack_active_i is high.
- R9: A cycle with ack_lvl_we_i high sets the level bit to ack_lvl_wdata_i on the next edge. When HAS_DACK_PIN = 0 the level bit reads 0 and writes have no effect.
- R10: After reset both addresses are 0, ack_lvl_o is 0 and dack_o is 1 while ack_active_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_load_i | input | 1 | Load strobe for the source address |
| src_load_val_i | input | AW | Source start address |
| dst_load_i | input | 1 | Load strobe for the destination address |
| dst_load_val_i | input | AW | Destination start address |
| src_mode_i | input | 2 | Source address mode |
| dst_mode_i | input | 2 | Destination address mode |
| size_i | input | 2 | Transfer-size code |
| single_addr_i | input | 1 | Single-address mode enable |
| dev_to_mem_i | input | 1 | In single-address mode, 1 = data comes from the device |
| xfer_done_i | input | 1 | A transfer has completed |
| ack_active_i | input | 1 | Acknowledge strobe request |
| ack_lvl_we_i | input | 1 | Write enable for the strobe level bit |
| ack_lvl_wdata_i | input | 1 | New strobe level |
| src_addr_o | output | AW | Current source address |
| dst_addr_o | output | AW | Current destination address |
| config_error_o | output | 1 | Prohibited mode and size combination |
| ack_lvl_o | output | 1 | Current strobe level bit |
| dack_o | output | 1 | Acknowledge strobe to the device |

## Verification
A load strobe and a transfer completion can land in the same cycle, and so can a completion and a prohibited configuration. The bench drives these cases both as directed cases and through random stimulus, where loads, completions and all mode and size codes overlap freely. A reference model picks the winner: a load beats an update, and an error blocks the update. The bench compares both addresses one edge later.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    AM_FIXED = 2'b00,
    AM_INC   = 2'b01,
    AM_DEC   = 2'b10,
    AM_RSVD  = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_LONG  = 2'b10,
    SZ_BURST = 2'b11
  } xfer_size_e;

  localparam int unsigned STEP_W = 5;

  function automatic logic [STEP_W-1:0] size_step(xfer_size_e s);
    case (s)
      SZ_BYTE:  return 5'd1;
      SZ_WORD:  return 5'd2;
      SZ_LONG:  return 5'd4;
      default:  return 5'd16;
    endcase
  endfunction

  // burst size only allows incrementing addresses
  function automatic logic mode_illegal(addr_mode_e m, xfer_size_e s);
    if (m == AM_RSVD) return 1'b1;
    if (s == SZ_BURST && m != AM_INC) return 1'b1;
    return 1'b0;
  endfunction

endpackage

// File: rtl/dma_cfg_check.sv
module dma_cfg_check
  import dma_seq_pkg::*;
(
  input  addr_mode_e src_mode_i,
  input  addr_mode_e dst_mode_i,
  input  xfer_size_e size_i,
  input  logic       single_addr_i,
  input  logic       dev_to_mem_i,
  output logic       src_used_o,
  output logic       dst_used_o,
  output logic       err_o
);

  always_comb begin
    src_used_o = !(single_addr_i && dev_to_mem_i);
    dst_used_o = !(single_addr_i && !dev_to_mem_i);
    err_o      = (src_used_o && mode_illegal(src_mode_i, size_i)) ||
                 (dst_used_o && mode_illegal(dst_mode_i, size_i));
  end

endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [AW-1:0]     load_val_i,
  input  logic              adv_i,
  input  addr_mode_e        mode_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [AW-1:0]     addr_o
);

  logic [AW-1:0] addr_q, addr_d, step_ext;

  assign step_ext = AW'(step_i);

  always_comb begin
    addr_d = addr_q;
    if (load_i) begin
      addr_d = load_val_i;
    end else if (adv_i) begin
      case (mode_i)
        AM_INC:  addr_d = addr_q + step_ext;
        AM_DEC:  addr_d = addr_q - step_ext;
        default: addr_d = addr_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_d;
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/dma_dack_ctrl.sv
module dma_dack_ctrl #(
  parameter bit HAS_DACK_PIN = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_we_i,
  input  logic lvl_wdata_i,
  input  logic ack_active_i,
  output logic lvl_o,
  output logic dack_o
);

  logic lvl_q;

  generate
    if (HAS_DACK_PIN) begin : g_lvl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       lvl_q <= 1'b0;
        else if (lvl_we_i) lvl_q <= lvl_wdata_i;
      end
    end else begin : g_no_lvl
      logic unused_w;
      assign unused_w = clk_i ^ rst_ni ^ lvl_we_i ^ lvl_wdata_i;
      assign lvl_q    = 1'b0;
    end
  endgenerate

  assign lvl_o  = lvl_q;
  assign dack_o = lvl_q ? ack_active_i : !ack_active_i;

endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW           = 32,
  parameter bit          HAS_DACK_PIN = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          src_load_i,
  input  logic [AW-1:0] src_load_val_i,
  input  logic          dst_load_i,
  input  logic [AW-1:0] dst_load_val_i,
  input  logic [1:0]    src_mode_i,
  input  logic [1:0]    dst_mode_i,
  input  logic [1:0]    size_i,
  input  logic          single_addr_i,
  input  logic          dev_to_mem_i,
  input  logic          xfer_done_i,
  input  logic          ack_active_i,
  input  logic          ack_lvl_we_i,
  input  logic          ack_lvl_wdata_i,
  output logic [AW-1:0] src_addr_o,
  output logic [AW-1:0] dst_addr_o,
  output logic          config_error_o,
  output logic          ack_lvl_o,
  output logic          dack_o
);

  addr_mode_e        src_mode, dst_mode;
  xfer_size_e        size;
  logic              src_used, dst_used, cfg_err;
  logic [STEP_W-1:0] step;
  logic              adv_ok;

  assign src_mode = addr_mode_e'(src_mode_i);
  assign dst_mode = addr_mode_e'(dst_mode_i);
  assign size     = xfer_size_e'(size_i);
  assign step     = size_step(size);
  assign adv_ok   = xfer_done_i && !cfg_err;

  dma_cfg_check u_cfg (
    .src_mode_i    (src_mode),
    .dst_mode_i    (dst_mode),
    .size_i        (size),
    .single_addr_i (single_addr_i),
    .dev_to_mem_i  (dev_to_mem_i),
    .src_used_o    (src_used),
    .dst_used_o    (dst_used),
    .err_o         (cfg_err)
  );

  dma_addr_unit #(.AW(AW)) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (src_load_i),
    .load_val_i (src_load_val_i),
    .adv_i      (adv_ok && src_used),
    .mode_i     (src_mode),
    .step_i     (step),
    .addr_o     (src_addr_o)
  );

  dma_addr_unit #(.AW(AW)) u_dst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (dst_load_i),
    .load_val_i (dst_load_val_i),
    .adv_i      (adv_ok && dst_used),
    .mode_i     (dst_mode),
    .step_i     (step),
    .addr_o     (dst_addr_o)
  );

  dma_dack_ctrl #(.HAS_DACK_PIN(HAS_DACK_PIN)) u_dack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lvl_we_i     (ack_lvl_we_i),
    .lvl_wdata_i  (ack_lvl_wdata_i),
    .ack_active_i (ack_active_i),
    .lvl_o        (ack_lvl_o),
    .dack_o       (dack_o)
  );

  assign config_error_o = cfg_err;

endmodule

// File: rtl/dma_addr_seq_chk.sv
module dma_addr_seq_chk
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW           = 32,
  parameter bit          HAS_DACK_PIN = 1'b1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          src_load_i,
  input logic [AW-1:0] src_load_val_i,
  input logic          dst_load_i,
  input logic [AW-1:0] dst_load_val_i,
  input logic [1:0]    src_mode_i,
  input logic [1:0]    size_i,
  input logic          single_addr_i,
  input logic          dev_to_mem_i,
  input logic          xfer_done_i,
  input logic          ack_active_i,
  input logic [AW-1:0] src_addr_o,
  input logic [AW-1:0] dst_addr_o,
  input logic          config_error_o,
  input logic          ack_lvl_o,
  input logic          dack_o
);

  logic src_side;
  assign src_side = !(single_addr_i && dev_to_mem_i);

  a_r1_src_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_done_i && !src_load_i && src_mode_i == 2'b00) |=> $stable(src_addr_o));

  a_r1_src_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_done_i && !config_error_o && !src_load_i && src_side && src_mode_i == 2'b01)
    |=> src_addr_o == $past(src_addr_o) + AW'(size_step(xfer_size_e'($past(size_i)))));

  a_r3_rsvd_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_side && src_mode_i == 2'b11) |-> config_error_o);

  a_r5_err_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (config_error_o && !src_load_i && !dst_load_i)
    |=> ($stable(src_addr_o) && $stable(dst_addr_o)));

  a_r6_src_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_load_i |=> src_addr_o == $past(src_load_val_i));

  a_r6_dst_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_load_i |=> dst_addr_o == $past(dst_load_val_i));

  a_r7_src_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_side && !src_load_i) |=> $stable(src_addr_o));

  a_r8_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_active_i |-> dack_o == !ack_lvl_o);

  generate
    if (!HAS_DACK_PIN) begin : g_nopin
      a_r9_lvl_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_lvl_o == 1'b0);
    end
  endgenerate

endmodule

bind dma_addr_seq dma_addr_seq_chk #(.AW(AW), .HAS_DACK_PIN(HAS_DACK_PIN)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .src_load_i     (src_load_i),
  .src_load_val_i (src_load_val_i),
  .dst_load_i     (dst_load_i),
  .dst_load_val_i (dst_load_val_i),
  .src_mode_i     (src_mode_i),
  .size_i         (size_i),
  .single_addr_i  (single_addr_i),
  .dev_to_mem_i   (dev_to_mem_i),
  .xfer_done_i    (xfer_done_i),
  .ack_active_i   (ack_active_i),
  .src_addr_o     (src_addr_o),
  .dst_addr_o     (dst_addr_o),
  .config_error_o (config_error_o),
  .ack_lvl_o      (ack_lvl_o),
  .dack_o         (dack_o)
);

// File: tb/tb_dma_addr_seq.sv
`timescale 1ns/1ps
module tb_dma_addr_seq;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        src_load_i = 0, dst_load_i = 0;
  logic [31:0] src_load_val_i = 0, dst_load_val_i = 0;
  logic [1:0]  src_mode_i = 0, dst_mode_i = 0, size_i = 0;
  logic        single_addr_i = 0, dev_to_mem_i = 0, xfer_done_i = 0;
  logic        ack_active_i = 0, ack_lvl_we_i = 0, ack_lvl_wdata_i = 0;
  logic [31:0] src_addr_o, dst_addr_o, src2, dst2;
  logic        config_error_o, ack_lvl_o, dack_o, err2, lvl2, dack2;

  always #2.5 clk_i = ~clk_i;

  dma_addr_seq dut (.*);

  dma_addr_seq #(.HAS_DACK_PIN(1'b0)) dut_nopin (
    .clk_i, .rst_ni, .src_load_i, .src_load_val_i, .dst_load_i, .dst_load_val_i,
    .src_mode_i, .dst_mode_i, .size_i, .single_addr_i, .dev_to_mem_i,
    .xfer_done_i, .ack_active_i, .ack_lvl_we_i, .ack_lvl_wdata_i,
    .src_addr_o(src2), .dst_addr_o(dst2), .config_error_o(err2),
    .ack_lvl_o(lvl2), .dack_o(dack2));

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] m_src = 0, m_dst = 0;
  logic        m_lvl = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] stp(logic [1:0] sz);
    case (sz)
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 4;
      default: return 16;
    endcase
  endfunction

  function automatic bit prohib(logic [1:0] m, logic [1:0] sz);
    return (m == 2'b11) || (sz == 2'b11 && m != 2'b01);
  endfunction

  function automatic logic [31:0] mv(logic [31:0] a, logic [1:0] m, logic [1:0] sz);
    if (m == 2'b01) return a + stp(sz);
    if (m == 2'b10) return a - stp(sz);
    return a;
  endfunction

  // inputs are already set; samples 1 ns after an edge
  task automatic cycle(string tag);
    bit su, du, e;
    logic [31:0] ns, nd;
    logic nl;
    su = !(single_addr_i && dev_to_mem_i);
    du = !(single_addr_i && !dev_to_mem_i);
    e  = (su && prohib(src_mode_i, size_i)) || (du && prohib(dst_mode_i, size_i));
    #0.5;
    chk(config_error_o == e, "R3 R4 config_error", 32'(config_error_o), 32'(e));
    chk(dack_o == (m_lvl ? ack_active_i : !ack_active_i), "R8 dack", 32'(dack_o),
        32'(m_lvl ? ack_active_i : !ack_active_i));
    chk(dack2 == !ack_active_i, "R9 dack no pin", 32'(dack2), 32'(!ack_active_i));
    ns = src_load_i ? src_load_val_i :
         (xfer_done_i && !e && su) ? mv(m_src, src_mode_i, size_i) : m_src;
    nd = dst_load_i ? dst_load_val_i :
         (xfer_done_i && !e && du) ? mv(m_dst, dst_mode_i, size_i) : m_dst;
    nl = ack_lvl_we_i ? ack_lvl_wdata_i : m_lvl;
    @(posedge clk_i);
    #1;
    m_src = ns; m_dst = nd; m_lvl = nl;
    chk(src_addr_o == m_src, {tag, " src"}, src_addr_o, m_src);
    chk(dst_addr_o == m_dst, {tag, " dst"}, dst_addr_o, m_dst);
    chk(ack_lvl_o == m_lvl, "R9 level", 32'(ack_lvl_o), 32'(m_lvl));
    chk(lvl2 == 1'b0, "R9 level no pin", 32'(lvl2), 0);
  endtask

  task automatic idle();
    src_load_i = 0; dst_load_i = 0; xfer_done_i = 0; ack_lvl_we_i = 0;
    single_addr_i = 0; ack_active_i = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk_i);
    #1;
    // R10 reset state
    chk(src_addr_o == 0, "R10 src reset", src_addr_o, 0);
    chk(dst_addr_o == 0, "R10 dst reset", dst_addr_o, 0);
    chk(ack_lvl_o == 0, "R10 level reset", 32'(ack_lvl_o), 0);
    chk(dack_o == 1, "R10 dack idle", 32'(dack_o), 1);
    rst_ni = 1;
    @(posedge clk_i); #1;

    // R6 load both
    src_load_i = 1; src_load_val_i = 32'hFFFF_FFF8;
    dst_load_i = 1; dst_load_val_i = 32'h0000_0008;
    cycle("R6 load");
    idle();
    // R1/R2 longword inc and dec, then wrap of the source
    src_mode_i = 2'b01; dst_mode_i = 2'b10; size_i = 2'b10; xfer_done_i = 1;
    cycle("R1 step long");
    cycle("R2 wrap");
    cycle("R2 dst wrap");
    // R1 burst inc
    dst_mode_i = 2'b01; size_i = 2'b11;
    cycle("R1 burst");
    // R4 burst with fixed source, R5 hold
    src_mode_i = 2'b00;
    cycle("R5 hold burst fixed");
    // R3 reserved on destination
    src_mode_i = 2'b01; dst_mode_i = 2'b11; size_i = 2'b00;
    cycle("R5 hold reserved");
    // R6 load and update in the same cycle
    dst_mode_i = 2'b01; src_load_i = 1; src_load_val_i = 32'h1000;
    cycle("R6 load wins");
    src_load_i = 0;
    // R7 single address: source side ignored, reserved mode on it
    single_addr_i = 1; dev_to_mem_i = 1; src_mode_i = 2'b11; size_i = 2'b01;
    cycle("R7 src ignored");
    dev_to_mem_i = 0; src_mode_i = 2'b10; dst_mode_i = 2'b11;
    cycle("R7 dst ignored");
    idle();
    // R8/R9 polarity
    ack_lvl_we_i = 1; ack_lvl_wdata_i = 1;
    cycle("R9 write");
    ack_lvl_we_i = 0; ack_active_i = 1;
    cycle("R8 active high");
    ack_active_i = 0;
    cycle("R8 idle high pol");

    for (int i = 0; i < 4000; i++) begin
      src_mode_i      = 2'($urandom);
      dst_mode_i      = 2'($urandom);
      size_i          = 2'($urandom);
      single_addr_i   = ($urandom % 4) == 0;
      dev_to_mem_i    = 1'($urandom);
      xfer_done_i     = 1'($urandom);
      src_load_i      = ($urandom % 10) == 0;
      dst_load_i      = ($urandom % 10) == 0;
      src_load_val_i  = $urandom;
      dst_load_val_i  = (i % 50 == 0) ? 32'hFFFF_FFF0 : $urandom;
      ack_active_i    = 1'($urandom);
      ack_lvl_we_i    = ($urandom % 16) == 0;
      ack_lvl_wdata_i = 1'($urandom);
      cycle("R1 R2 R5 R6 R7 random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule